// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a memory client and a four-bank double-data-rate SDRAM. The client hands it one access at a time: a direction, a bank, a row and a starting column. It also raises a level-sensitive refresh request from time to time. The sequencer turns these into a stream of device commands, at most one per clock. The commands are row activate, column read, column write, single-bank or all-bank precharge, and auto refresh. Clocks in which nothing may legally be sent carry a no-operation code.

The sequencer keeps, for every bank, whether a row is open and which row it is. An access that lands on the open row goes straight to the column command. An access to a closed bank is activated first. An access that misses the open row first closes that row and then opens the new one. Down-counters enforce the activate-to-column delay, the precharge-to-activate delay, the refresh recovery time and the data-bus occupancy of a burst. Burst length, CAS latency and the auto-precharge option are static configuration inputs. A read-valid strobe marks the clocks in which read data returns. A half-clock CAS latency is rounded up to a whole clock.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_o` is NOP (0), `rd_valid` and `ref_ack` are low and `req_ready` is high.
- R2: An access to a closed bank issues ACTIVE (`cmd_o`=1, `cmd_addr`=row) and then, exactly 3 clocks later, READ (2) or WRITE (3), with `cmd_addr`=column and the same bank. No column command reaches a bank less than 3 clocks after its ACTIVE.
- R3: An access whose row equals the open row of its bank issues only the READ or WRITE command, with no ACTIVE or PRECHARGE before it.
- R4: An access to a bank that has a different row open issues PRECHARGE (4, `cmd_ap`=0) to that bank. It then issues ACTIVE 3 clocks later and the column command 3 clocks after that.
- R5: With `cfg_auto_pre`=1, the column command carries `cmd_ap`=1 and its bank counts as closed. The next ACTIVE to that bank comes no sooner than burst clocks plus 3 after the column command.
- R6: `cfg_bl` selects the burst: 0 gives 2 words, 1 gives 4 words, and 2 or 3 gives 8 words. The burst holds the data bus for half that many clocks. Two column commands are at least that many clocks apart.
- R7: `cfg_cas` selects the CAS latency: 0 gives 2 clocks, 1 gives 2.5 clocks (rounded to 3), and 2 or 3 gives 3 clocks. `rd_valid` goes high that many clocks after READ appears on `cmd_o` and stays high for burst/2 clocks. Windows of back-to-back reads join without a gap.
- R8: A held `ref_req` takes precedence over a pending access once the data bus is free. If any row is open, the sequencer issues PRECHARGE with `cmd_ap`=1 (all banks) first. It then issues AUTO REFRESH (5) once every bank has finished precharging. `ref_ack` is high in exactly the cycle in which REFRESH is on `cmd_o`.
- R9: At most one command is issued per clock, and all other clocks carry NOP. `req_ready` is low from the clock after a request is accepted until its column command has been issued.
- R10: No ACTIVE is issued sooner than 8 clocks (the refresh recovery time) after AUTO REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request slot free; a request is taken when valid and ready are both high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| ref_req | input | 1 | Refresh wanted; hold until acknowledged |
| ref_ack | output | 1 | High in the cycle AUTO REFRESH is issued |
| cfg_bl | input | 2 | Burst-length select |
| cfg_cas | input | 2 | CAS-latency select |
| cfg_auto_pre | input | 1 | Close the row automatically after each burst |
| cmd_o | output | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | 13 | Row for ACTIVE, column for READ/WRITE |
| cmd_ap | output | 1 | Auto-precharge on READ/WRITE; all banks on PRECHARGE |
| rd_valid | output | 1 | Read data returns in this clock |

## Verification
The properties assume that the configuration inputs stay still while a burst and its read window are in progress. They also assume that `ref_req` is held until `ref_ack` and then dropped, and that request fields are stable in the clock where valid and ready meet. The stimulus follows these rules. It changes `cfg_bl`, `cfg_cas` and `cfg_auto_pre` only after the previous access has been seen on the command output. It clears `ref_req` in the same clock that it observes the acknowledge. It drives each request for a single accepting edge, after seeing `req_ready` high.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    localparam int BEAT_W = 3;

    // data-bus clocks a burst occupies (burst length / 2)
    function automatic logic [BEAT_W-1:0] bus_clocks(input logic [1:0] bl_sel);
        case (bl_sel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // CAS latency rounded up to whole clocks
    function automatic logic [1:0] cas_clocks(input logic [1:0] cas_sel);
        return (cas_sel == 2'd0) ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_seq_pkg::*;
#(
    parameter int NB    = 4,
    parameter int BA_W  = $clog2(NB),
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  cmd_e                       iss_cmd,
    input  logic [BA_W-1:0]            iss_bank,
    input  logic [ROW_W-1:0]           iss_row,
    input  logic                       iss_ap,
    input  logic [BEAT_W-1:0]          iss_beats,
    output logic [NB-1:0]              bank_open,
    output logic [NB-1:0][ROW_W-1:0]   open_row,
    output logic [NB-1:0]              act_ok,
    output logic [NB-1:0]              acc_ok
);

    localparam int CNT_W = $clog2(T_RCD + T_RP + 8);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] rcd;
        logic [CNT_W-1:0] rp;
    } bank_t;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        bank_t b_d, b_q;
        logic  sel;

        always_comb begin
            sel = (iss_bank == BA_W'(g));
            b_d = b_q;
            if (b_q.rcd != '0) b_d.rcd = b_q.rcd - 1'b1;
            if (b_q.rp  != '0) b_d.rp  = b_q.rp  - 1'b1;
            case (iss_cmd)
                CMD_ACT: if (sel) begin
                    b_d.open = 1'b1;
                    b_d.row  = iss_row;
                    b_d.rcd  = CNT_W'(T_RCD - 1);
                end
                CMD_RD, CMD_WR: if (sel && iss_ap) begin
                    b_d.open = 1'b0;
                    b_d.rp   = CNT_W'(iss_beats) + CNT_W'(T_RP - 1);
                end
                CMD_PRE: if ((sel || iss_ap) && b_q.open) begin
                    b_d.open = 1'b0;
                    b_d.rp   = CNT_W'(T_RP - 1);
                end
                default: ;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        assign bank_open[g] = b_q.open;
        assign open_row[g]  = b_q.row;
        assign act_ok[g]    = (b_q.rp == '0);
        assign acc_ok[g]    = (b_q.rcd == '0);
    end

    p_act_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_cmd == CMD_ACT |-> !bank_open[iss_bank] && act_ok[iss_bank]);

    p_acc_timed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_cmd == CMD_RD || iss_cmd == CMD_WR) |-> bank_open[iss_bank] && acc_ok[iss_bank]);

    p_ref_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_cmd == CMD_REF |-> (bank_open == '0) && (&act_ok));

    p_ap_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_cmd == CMD_RD || iss_cmd == CMD_WR) && iss_ap) |=> !bank_open[$past(iss_bank)]);

endmodule

// File: rtl/ddr_rd_window.sv
module ddr_rd_window
    import ddr_seq_pkg::*;
#(
    parameter int MAX_CL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_issue,
    input  logic [1:0] cfg_cas,
    input  logic [1:0] cfg_bl,
    output logic       rd_valid
);

    typedef struct packed {
        logic [MAX_CL-1:0] sh;
        logic [BEAT_W-1:0] len;
    } win_t;

    win_t w_d, w_q;
    logic tap;

    always_comb begin
        w_d    = w_q;
        w_d.sh = {w_q.sh[MAX_CL-2:0], rd_issue};
        tap    = w_q.sh[int'(cas_clocks(cfg_cas)) - 1];
        if (tap)                 w_d.len = bus_clocks(cfg_bl);
        else if (w_q.len != '0)  w_d.len = w_q.len - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign rd_valid = (w_q.len != '0);

    p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.len <= BEAT_W'(4));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int NB    = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RFC = 8,
    localparam int BA_W   = $clog2(NB),
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              ref_req,
    output logic              ref_ack,
    input  logic [1:0]        cfg_bl,
    input  logic [1:0]        cfg_cas,
    input  logic              cfg_auto_pre,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ap,
    output logic              rd_valid
);

    localparam int RFC_W = $clog2(T_RFC + 1);

    typedef struct packed {
        logic              pend;
        logic              p_wr;
        logic [BA_W-1:0]   p_bank;
        logic [ROW_W-1:0]  p_row;
        logic [COL_W-1:0]  p_col;
        logic [BEAT_W-1:0] bus;
        logic [RFC_W-1:0]  rfc;
        cmd_e              cmd;
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] addr;
        logic              ap;
        logic              ack;
    } seq_t;

    seq_t s_d, s_q;

    logic [NB-1:0]            bank_open;
    logic [NB-1:0][ROW_W-1:0] open_row;
    logic [NB-1:0]            act_ok;
    logic [NB-1:0]            acc_ok;
    logic                     row_hit;
    logic [BEAT_W-1:0]        beats;

    assign beats = bus_clocks(cfg_bl);

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.bank = '0;
        s_d.addr = '0;
        s_d.ap   = 1'b0;
        s_d.ack  = 1'b0;
        if (s_q.bus != '0) s_d.bus = s_q.bus - 1'b1;
        if (s_q.rfc != '0) s_d.rfc = s_q.rfc - 1'b1;
        row_hit = bank_open[s_q.p_bank] && (open_row[s_q.p_bank] == s_q.p_row);

        if (!s_q.pend && req_valid) begin
            s_d.pend   = 1'b1;
            s_d.p_wr   = req_write;
            s_d.p_bank = req_bank;
            s_d.p_row  = req_row;
            s_d.p_col  = req_col;
        end

        if (ref_req) begin
            if (s_q.bus == '0) begin
                if (|bank_open) begin
                    s_d.cmd = CMD_PRE;
                    s_d.ap  = 1'b1;
                end else if ((&act_ok) && s_q.rfc == '0) begin
                    s_d.cmd = CMD_REF;
                    s_d.ack = 1'b1;
                    s_d.rfc = RFC_W'(T_RFC - 1);
                end
            end
        end else if (s_q.pend) begin
            if (row_hit) begin
                if (acc_ok[s_q.p_bank] && s_q.bus == '0) begin
                    s_d.cmd  = s_q.p_wr ? CMD_WR : CMD_RD;
                    s_d.bank = s_q.p_bank;
                    s_d.addr = ADDR_W'(s_q.p_col);
                    s_d.ap   = cfg_auto_pre;
                    s_d.bus  = beats - 1'b1;
                    s_d.pend = 1'b0;
                end
            end else if (bank_open[s_q.p_bank]) begin
                if (s_q.bus == '0) begin
                    s_d.cmd  = CMD_PRE;
                    s_d.bank = s_q.p_bank;
                end
            end else if (act_ok[s_q.p_bank] && s_q.rfc == '0) begin
                s_d.cmd  = CMD_ACT;
                s_d.bank = s_q.p_bank;
                s_d.addr = ADDR_W'(s_q.p_row);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ddr_bank_track #(
        .NB(NB), .BA_W(BA_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)
    ) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_cmd   (s_d.cmd),
        .iss_bank  (s_d.bank),
        .iss_row   (s_q.p_row),
        .iss_ap    (s_d.ap),
        .iss_beats (beats),
        .bank_open (bank_open),
        .open_row  (open_row),
        .act_ok    (act_ok),
        .acc_ok    (acc_ok)
    );

    ddr_rd_window #(.MAX_CL(3)) i_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (s_d.cmd == CMD_RD),
        .cfg_cas  (cfg_cas),
        .cfg_bl   (cfg_bl),
        .rd_valid (rd_valid)
    );

    assign req_ready = !s_q.pend;
    assign ref_ack   = s_q.ack;
    assign cmd_o     = s_q.cmd;
    assign cmd_bank  = s_q.bank;
    assign cmd_addr  = s_q.addr;
    assign cmd_ap    = s_q.ap;

    p_act_gap1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == CMD_ACT |=> !((cmd_o == CMD_RD || cmd_o == CMD_WR) && cmd_bank == $past(cmd_bank)));

    p_act_gap2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_o, 2) == CMD_ACT && (cmd_o == CMD_RD || cmd_o == CMD_WR)) |-> cmd_bank != $past(cmd_bank, 2));

    p_hold_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_bus_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_RD || cmd_o == CMD_WR) && cfg_bl != 2'd0) |=> !(cmd_o == CMD_RD || cmd_o == CMD_WR));

    p_rdv_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> ($past(cmd_o, 2) == CMD_RD || $past(cmd_o, 3) == CMD_RD));

endmodule

// File: tb/test_ddr_cmd_seq.sv
module test_ddr_cmd_seq;

    typedef struct packed {
        logic        wr;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic [1:0]  bl;
        logic [1:0]  cas;
        logic        ap;
        logic [1:0]  kind;   // 0 hit, 1 closed bank, 2 row miss
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 13'd5, 10'd16, 2'd1, 2'd0, 1'b0, 2'd1},
        '{1'b0, 2'd0, 13'd5, 10'd20, 2'd1, 2'd0, 1'b0, 2'd0},
        '{1'b0, 2'd0, 13'd9, 10'd4,  2'd0, 2'd2, 1'b0, 2'd2},
        '{1'b1, 2'd1, 13'd2, 10'd8,  2'd1, 2'd0, 1'b1, 2'd1},
        '{1'b0, 2'd1, 13'd2, 10'd12, 2'd2, 2'd1, 1'b0, 2'd1},
        '{1'b0, 2'd2, 13'd7, 10'd0,  2'd2, 2'd2, 1'b0, 2'd1},
        '{1'b0, 2'd2, 13'd7, 10'd2,  2'd0, 2'd0, 1'b0, 2'd0},
        '{1'b1, 2'd3, 13'd1, 10'd30, 2'd1, 2'd0, 1'b0, 2'd1},
        '{1'b0, 2'd3, 13'd1, 10'd32, 2'd1, 2'd1, 1'b0, 2'd0},
        '{1'b0, 2'd3, 13'd6, 10'd40, 2'd2, 2'd0, 1'b1, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        ref_req = 1'b0, ref_ack;
    logic [1:0]  cfg_bl = 2'd1, cfg_cas = 2'd0;
    logic        cfg_auto_pre = 1'b0;
    logic [2:0]  cmd_o;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr;
    logic        cmd_ap, rd_valid;

    always #2 clk = ~clk;

    ddr_cmd_seq i_ddr_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .ref_req(ref_req), .ref_ack(ref_ack), .cfg_bl(cfg_bl), .cfg_cas(cfg_cas),
        .cfg_auto_pre(cfg_auto_pre), .cmd_o(cmd_o), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_ap(cmd_ap), .rd_valid(rd_valid)
    );

    int checks = 0, fails = 0, cyc = 0, nlog = 0;
    int lg_cmd [256], lg_bank [256], lg_addr [256], lg_ap [256], lg_cyc [256];
    bit rv [4096];

    // command log, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (cyc < 4096) rv[cyc] = rd_valid;
        if (rst_n && cmd_o != 3'd0 && nlog < 256) begin
            lg_cmd[nlog]  = int'(cmd_o);
            lg_bank[nlog] = int'(cmd_bank);
            lg_addr[nlog] = int'(cmd_addr);
            lg_ap[nlog]   = int'(cmd_ap);
            lg_cyc[nlog]  = cyc;
            nlog++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 5000) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 5000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic send(input bit wr, input int bank, input int row, input int col);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr;
        req_bank  = 2'(bank);
        req_row   = 13'(row);
        req_col   = 10'(col);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low while request held", int'(req_ready), 0);
    endtask

    task automatic find_access(input int from, output int pos);
        pos = -1;
        for (int w = 0; w < 200 && pos < 0; w++) begin
            for (int i = from; i < nlog; i++)
                if (pos < 0 && (lg_cmd[i] == 2 || lg_cmd[i] == 3)) pos = i;
            if (pos < 0) @(negedge clk);
        end
    endtask

    task automatic check_window(input int c0, input int cl, input int beats, input string tag);
        int hi = 0;
        for (int k = 0; k < beats; k++) if (rv[c0 + cl + k]) hi++;
        chk(hi == beats && !rv[c0 + cl - 1] && !rv[c0 + cl + beats], tag, hi, beats);
    endtask

    initial begin
        int i0, pa, pb, en, cl, bt, pr;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(cmd_o == 3'd0 && rd_valid == 1'b0 && ref_ack == 1'b0, "R1 outputs idle in reset",
            int'(cmd_o), 0);
        chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_o == 3'd0 && rd_valid == 1'b0 && req_ready == 1'b1, "R1 idle after reset",
            int'(cmd_o), 0);

        // vector table: R2 closed bank, R3 hit, R4 miss, R5 auto-precharge, R7 read window
        for (int v = 0; v < NV; v++) begin
            cfg_bl       = VECS[v].bl;
            cfg_cas      = VECS[v].cas;
            cfg_auto_pre = VECS[v].ap;
            i0 = nlog;
            send(VECS[v].wr, int'(VECS[v].bank), int'(VECS[v].row), int'(VECS[v].col));
            find_access(i0, pa);
            repeat (14) @(negedge clk);
            en = (VECS[v].kind == 2'd0) ? 1 : (VECS[v].kind == 2'd1) ? 2 : 3;
            chk(pa == i0 + en - 1, "R2 R3 R4 command sequence length", pa - i0 + 1, en);
            chk(nlog == i0 + en, "R9 no extra commands", nlog - i0, en);
            if (pa >= 0) begin
                chk(lg_cmd[pa] == (VECS[v].wr ? 3 : 2) && lg_bank[pa] == int'(VECS[v].bank),
                    "R2 column command code", lg_cmd[pa], VECS[v].wr ? 3 : 2);
                chk(lg_addr[pa] == int'(VECS[v].col), "R2 column address", lg_addr[pa],
                    int'(VECS[v].col));
                chk(lg_ap[pa] == int'(VECS[v].ap), "R5 auto-precharge flag", lg_ap[pa],
                    int'(VECS[v].ap));
                if (en >= 2 && pa >= 1) begin
                    chk(lg_cmd[pa-1] == 1 && lg_addr[pa-1] == int'(VECS[v].row),
                        "R2 activate with row", lg_addr[pa-1], int'(VECS[v].row));
                    chk(lg_cyc[pa] - lg_cyc[pa-1] == 3, "R2 activate to access gap",
                        lg_cyc[pa] - lg_cyc[pa-1], 3);
                end
                if (en == 3 && pa >= 2) begin
                    chk(lg_cmd[pa-2] == 4 && lg_ap[pa-2] == 0 && lg_bank[pa-2] == int'(VECS[v].bank),
                        "R4 single-bank precharge first", lg_cmd[pa-2], 4);
                    chk(lg_cyc[pa-1] - lg_cyc[pa-2] == 3, "R4 precharge to activate gap",
                        lg_cyc[pa-1] - lg_cyc[pa-2], 3);
                end
                if (!VECS[v].wr) begin
                    cl = (VECS[v].cas == 2'd0) ? 2 : 3;
                    bt = (VECS[v].bl == 2'd0) ? 1 : (VECS[v].bl == 2'd1) ? 2 : 4;
                    check_window(lg_cyc[pa], cl, bt, "R7 read-valid window");
                end
            end
        end

        // R8 refresh with open rows: precharge-all then refresh
        cfg_bl = 2'd0; cfg_cas = 2'd0; cfg_auto_pre = 1'b0;
        i0 = nlog;
        @(negedge clk);
        ref_req = 1'b1;
        for (int w = 0; w < 50 && !ref_ack; w++) @(negedge clk);
        chk(ref_ack == 1'b1 && cmd_o == 3'd5, "R8 ack together with refresh", int'(cmd_o), 5);
        ref_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(nlog == i0 + 2 && lg_cmd[i0] == 4 && lg_ap[i0] == 1, "R8 precharge-all first",
            lg_cmd[i0], 4);
        chk(lg_cmd[i0+1] == 5 && lg_cyc[i0+1] - lg_cyc[i0] == 3, "R8 refresh after precharge",
            lg_cyc[i0+1] - lg_cyc[i0], 3);
        pr = i0 + 1;

        // R10 refresh recovery before the next activate
        i0 = nlog;
        send(1'b0, 0, 9, 50);
        find_access(i0, pa);
        chk(pa == i0 + 1 && lg_cmd[i0] == 1, "R10 activate after refresh", pa - i0, 1);
        chk(lg_cyc[i0] - lg_cyc[pr] == 8, "R10 refresh to activate gap", lg_cyc[i0] - lg_cyc[pr], 8);
        repeat (10) @(negedge clk);

        // R6 / R7 back-to-back reads, 8-word bursts
        cfg_bl = 2'd2; cfg_cas = 2'd0;
        i0 = nlog;
        send(1'b0, 0, 9, 64);
        send(1'b0, 0, 9, 72);
        find_access(i0, pa);
        find_access(pa + 1, pb);
        repeat (14) @(negedge clk);
        chk(pb > pa && lg_cyc[pb] - lg_cyc[pa] == 4, "R6 column commands spaced by burst",
            lg_cyc[pb] - lg_cyc[pa], 4);
        check_window(lg_cyc[pa], 2, 8, "R7 joined windows of back-to-back reads");

        // R5 auto-precharge holds off the next activate
        cfg_auto_pre = 1'b1;
        i0 = nlog;
        send(1'b1, 0, 9, 5);
        find_access(i0, pa);
        cfg_auto_pre = 1'b0;
        send(1'b0, 0, 9, 9);
        find_access(pa + 1, pb);
        repeat (10) @(negedge clk);
        chk(pa == i0 && lg_ap[pa] == 1, "R5 write hit carries auto-precharge", lg_ap[pa], 1);
        chk(pb == pa + 2 && lg_cmd[pa+1] == 1, "R5 bank reopened by activate", lg_cmd[pa+1], 1);
        chk(lg_cyc[pa+1] - lg_cyc[pa] == 7, "R5 activate waits burst plus precharge",
            lg_cyc[pa+1] - lg_cyc[pa], 7);

        // R8 refresh waits for the current burst
        i0 = nlog;
        send(1'b0, 0, 9, 3);
        find_access(i0, pa);
        ref_req = 1'b1;
        for (int w = 0; w < 50 && !ref_ack; w++) @(negedge clk);
        ref_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(lg_cmd[pa+1] == 4 && lg_ap[pa+1] == 1 && lg_cyc[pa+1] - lg_cyc[pa] == 4,
            "R8 precharge-all after burst clears", lg_cyc[pa+1] - lg_cyc[pa], 4);
        chk(lg_cmd[pa+2] == 5 && lg_cyc[pa+2] - lg_cyc[pa+1] == 3, "R8 refresh follows",
            lg_cmd[pa+2], 5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule